// File: doc/BRIEF.md
# Burst Dimming Controller with Per-Burst Soft Start

This block turns a digital brightness level into a slow on/off burst gate for a lamp inverter's PWM stage and, at the start of every burst, supplies a duty-cycle ceiling that climbs from a small value to the normal maximum. Inside the block a sawtooth phase counter runs only while the system sequencer holds the block in run mode. The counter climbs one step every `PRESCALE` clocks from zero to all ones and then wraps. The gate is open while the phase is below the brightness level.

The brightness level is captured while the block is idle and again at each wrap of the phase counter. A burst therefore never changes width halfway through. An alternative mode passes an external PWM waveform straight to the gate and ignores the phase counter. An open-load override from the sequencer keeps the gate open for as long as it is asserted.

The soft-start ceiling follows the first part of each phase period. It is skipped when the brightness level is close to full scale, because the output is then nearly continuous.

Top module: `burst_dim_ctrl`

## Requirements
- R1: While `run_en` is high, the phase counter advances by one every `PRESCALE` clocks, counts from 0 up to 2^`RAMP_W`-1 and then wraps to 0.
- R2: The phase counter is 0 in the first cycle after `run_en` is sampled high. Its first step comes at the `PRESCALE`-th rising edge after that.
- R3: `dim_level` is captured at every clock while `run_en` is low, and at the step where the phase wraps from all ones to 0. A change of `dim_level` in the middle of a period has no effect on `burst_on` until the next wrap.
- R4: In ramp mode (`ext_mode`=0, `open_load`=0, run), `burst_on` is 1 when the phase is below the captured level or when the captured level is all ones. A captured level of 0 keeps the gate closed.
- R5: In external mode (`ext_mode`=1, `open_load`=0, run), `burst_on` equals `ext_pwm_in` in the same cycle, whatever the phase.
- R6: During run, `open_load`=1 forces `burst_on` to 1 in any mode.
- R7: While `run_en` is low, `burst_on` is 0 and `duty_limit` is 0.
- R8: In ramp mode, when the captured level is below `SS_OFF` and the phase is below `SS_END`, `duty_limit` = `DUTY_MIN` + floor((`DUTY_MAX`-`DUTY_MIN`) * phase / `SS_END`).
- R9: In every other run case, `duty_limit` = `DUTY_MAX`. These cases are: phase at or above `SS_END`, captured level at or above `SS_OFF`, external mode, or `open_load`.
- R10: During run, `duty_limit` always lies between `DUTY_MIN` and `DUTY_MAX`, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run mode from the sequencer; a rising level restarts the phase |
| ext_mode | input | 1 | 1 selects the external PWM pass-through |
| ext_pwm_in | input | 1 | External burst waveform |
| dim_level | input | RAMP_W | Brightness level; all ones means full |
| open_load | input | 1 | Override that forces the gate open |
| burst_on | output | 1 | Burst gate to the PWM block |
| duty_limit | output | DUTY_W | Duty ceiling to the PWM block |

## Verification
The assertions take all inputs to be synchronous to `clk` and expect the parameters to satisfy `DUTY_MIN` <= `DUTY_MAX`, 0 < `SS_END` < 2^`RAMP_W` and `SS_OFF` <= 2^`RAMP_W`-1. Under those conditions the ceiling stays in range and reaches its maximum once the phase passes `SS_END`. The stimulus changes every input only at the falling clock edge. It uses a reduced phase width and prescaler that keep these parameter relations. The levels it applies sit on and next to the `SS_OFF` boundary and at both ends of the scale.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

    // Which source drives the burst gate this cycle
    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_FORCE = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_RAMP  = 2'd3
    } gate_src_e;

    // Phase counter events
    typedef struct packed {
        logic step;
        logic wrap;
    } ramp_evt_t;

    // Priority: idle, then open-load override, then external, then ramp
    function automatic gate_src_e pick_src(input logic run, input logic force_on,
                                           input logic ext);
        if (!run)     return SRC_OFF;
        if (force_on) return SRC_FORCE;
        if (ext)      return SRC_EXT;
        return SRC_RAMP;
    endfunction

    // Linear ceiling between lo and hi across span phase steps
    function automatic int unsigned ss_interp(input int unsigned pos,
                                              input int unsigned span,
                                              input int unsigned lo,
                                              input int unsigned hi);
        return lo + ((hi - lo) * pos) / span;
    endfunction

endpackage

// File: rtl/bdc_ramp_gen.sv
module bdc_ramp_gen
    import bdc_pkg::*;
#(
    parameter int RAMP_W   = 8,
    parameter int PRESCALE = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    output logic [RAMP_W-1:0] ramp,
    output ramp_evt_t         evt
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(PRESCALE - 1);
    localparam logic [RAMP_W-1:0] RAMP_TOP = '1;

    logic [PRE_W-1:0] pre_q;

    always_comb begin
        evt.step = run_en && (pre_q == PRE_LAST);
        evt.wrap = evt.step && (ramp == RAMP_TOP);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            pre_q <= '0;
            ramp  <= '0;
        end else if (evt.step) begin
            pre_q <= '0;
            ramp  <= ramp + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R2
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (ramp == '0));

    // R1
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.step && !evt.wrap) |=> (ramp == RAMP_W'($past(ramp) + 1'b1)));

    // R1
    ramp_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        evt.wrap |=> (ramp == '0));

    // R1
    ramp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && !evt.step) |=> $stable(ramp));

endmodule

// File: rtl/bdc_level_hold.sv
module bdc_level_hold
    import bdc_pkg::*;
#(
    parameter int RAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  ramp_evt_t         evt,
    input  logic [RAMP_W-1:0] dim_level,
    output logic [RAMP_W-1:0] dim_q
);
    always_ff @(posedge clk) begin
        if (rst)
            dim_q <= '0;
        else if (!run_en || evt.wrap)
            dim_q <= dim_level;
    end

    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && !evt.wrap) |=> $stable(dim_q));

endmodule

// File: rtl/bdc_gate_mux.sv
module bdc_gate_mux
    import bdc_pkg::*;
#(
    parameter int RAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              force_on,
    input  logic              ext_mode,
    input  logic              ext_pwm,
    input  logic [RAMP_W-1:0] ramp,
    input  logic [RAMP_W-1:0] dim_q,
    output gate_src_e         src,
    output logic              gate
);
    localparam logic [RAMP_W-1:0] LVL_FULL = '1;

    always_comb begin
        src = pick_src(run_en, force_on, ext_mode);
        unique case (src)
            SRC_OFF:   gate = 1'b0;
            SRC_FORCE: gate = 1'b1;
            SRC_EXT:   gate = ext_pwm;
            default:   gate = (dim_q == LVL_FULL) || (ramp < dim_q);
        endcase
    end

    // R6
    force_on_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && force_on) |-> gate);

    // R4
    zero_level_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_RAMP && dim_q == '0) |-> !gate);

endmodule

// File: rtl/bdc_ss_limit.sv
module bdc_ss_limit
    import bdc_pkg::*;
#(
    parameter int RAMP_W   = 8,
    parameter int DUTY_W   = 8,
    parameter int DUTY_MIN = 26,
    parameter int DUTY_MAX = 118,
    parameter int SS_END   = 49,
    parameter int SS_OFF   = 246
) (
    input  logic              clk,
    input  logic              rst,
    input  gate_src_e         src,
    input  logic [RAMP_W-1:0] ramp,
    input  logic [RAMP_W-1:0] dim_q,
    output logic [DUTY_W-1:0] duty
);
    localparam logic [RAMP_W-1:0] SS_END_R = RAMP_W'(SS_END);
    localparam logic [RAMP_W-1:0] SS_OFF_R = RAMP_W'(SS_OFF);
    localparam logic [DUTY_W-1:0] DMIN_D   = DUTY_W'(DUTY_MIN);
    localparam logic [DUTY_W-1:0] DMAX_D   = DUTY_W'(DUTY_MAX);

    logic              ss_on;
    logic [DUTY_W-1:0] ramp_duty;

    always_comb begin
        ss_on     = (src == SRC_RAMP) && (dim_q < SS_OFF_R) && (ramp < SS_END_R);
        ramp_duty = DUTY_W'(ss_interp(32'(ramp), SS_END, DUTY_MIN, DUTY_MAX));
        if (src == SRC_OFF)
            duty = '0;
        else if (ss_on)
            duty = ramp_duty;
        else
            duty = DMAX_D;
    end

    // R10
    duty_range_chk: assert property (@(posedge clk) disable iff (rst)
        (src != SRC_OFF) |-> (duty >= DMIN_D && duty <= DMAX_D));

    // R9
    ss_done_chk: assert property (@(posedge clk) disable iff (rst)
        (src != SRC_OFF && ramp >= SS_END_R) |-> (duty == DMAX_D));

    // R8
    ss_start_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_RAMP && dim_q < SS_OFF_R && ramp == '0) |-> (duty == DMIN_D));

endmodule

// File: rtl/burst_dim_ctrl.sv
module burst_dim_ctrl
    import bdc_pkg::*;
#(
    parameter int RAMP_W   = 8,
    parameter int PRESCALE = 64,
    parameter int DUTY_W   = 8,
    parameter int DUTY_MIN = 26,
    parameter int DUTY_MAX = 118,
    parameter int SS_END   = 49,
    parameter int SS_OFF   = 246
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              ext_mode,
    input  logic              ext_pwm_in,
    input  logic [RAMP_W-1:0] dim_level,
    input  logic              open_load,
    output logic              burst_on,
    output logic [DUTY_W-1:0] duty_limit
);
    logic [RAMP_W-1:0] ramp;
    logic [RAMP_W-1:0] dim_q;
    ramp_evt_t         evt;
    gate_src_e         src;

    bdc_ramp_gen #(.RAMP_W(RAMP_W), .PRESCALE(PRESCALE)) u_ramp (
        .clk(clk), .rst(rst), .run_en(run_en), .ramp(ramp), .evt(evt)
    );

    bdc_level_hold #(.RAMP_W(RAMP_W)) u_hold (
        .clk(clk), .rst(rst), .run_en(run_en), .evt(evt),
        .dim_level(dim_level), .dim_q(dim_q)
    );

    bdc_gate_mux #(.RAMP_W(RAMP_W)) u_gate (
        .clk(clk), .rst(rst), .run_en(run_en), .force_on(open_load),
        .ext_mode(ext_mode), .ext_pwm(ext_pwm_in), .ramp(ramp),
        .dim_q(dim_q), .src(src), .gate(burst_on)
    );

    bdc_ss_limit #(
        .RAMP_W(RAMP_W), .DUTY_W(DUTY_W), .DUTY_MIN(DUTY_MIN),
        .DUTY_MAX(DUTY_MAX), .SS_END(SS_END), .SS_OFF(SS_OFF)
    ) u_ss (
        .clk(clk), .rst(rst), .src(src), .ramp(ramp), .dim_q(dim_q),
        .duty(duty_limit)
    );

    // R7
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> (!burst_on && duty_limit == '0));

    // R5
    ext_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && ext_mode && !open_load) |-> (burst_on == ext_pwm_in));

endmodule

// File: tb/burst_dim_ctrl_tb.sv
`timescale 1ns/1ps
module burst_dim_ctrl_tb;
    localparam int RW     = 6;
    localparam int PS     = 2;
    localparam int DW     = 8;
    localparam int DMIN   = 26;
    localparam int DMAX   = 118;
    localparam int SSE    = 12;
    localparam int SSO    = 61;
    localparam int RSTEPS = 1 << RW;
    localparam int FULL   = RSTEPS - 1;

    typedef struct packed {
        logic [RW-1:0] dim;
        logic          ext;
        logic          pwm;
        logic          ol;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{6'd20, 1'b0, 1'b0, 1'b0},
        '{6'd0,  1'b0, 1'b0, 1'b0},
        '{6'd63, 1'b0, 1'b0, 1'b0},
        '{6'd60, 1'b0, 1'b0, 1'b0},
        '{6'd61, 1'b0, 1'b0, 1'b0},
        '{6'd5,  1'b1, 1'b1, 1'b0},
        '{6'd40, 1'b1, 1'b0, 1'b0},
        '{6'd0,  1'b0, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_en = 1'b0;
    logic          ext_mode = 1'b0;
    logic          ext_pwm_in = 1'b0;
    logic [RW-1:0] dim_level = '0;
    logic          open_load = 1'b0;
    logic          burst_on;
    logic [DW-1:0] duty_limit;

    int n = 0;
    int dim_m = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_dim_ctrl #(
        .RAMP_W(RW), .PRESCALE(PS), .DUTY_W(DW), .DUTY_MIN(DMIN),
        .DUTY_MAX(DMAX), .SS_END(SSE), .SS_OFF(SSO)
    ) u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .ext_mode(ext_mode),
        .ext_pwm_in(ext_pwm_in), .dim_level(dim_level), .open_load(open_load),
        .burst_on(burst_on), .duty_limit(duty_limit)
    );

    // One rising edge with the reference model updated, then wait for the falling edge
    task automatic tick();
        @(posedge clk);
        if (rst || !run_en) begin
            n     = 0;
            dim_m = rst ? 0 : int'(dim_level);
        end else begin
            if ((n % PS) == PS - 1 && ((n / PS) % RSTEPS) == FULL)
                dim_m = int'(dim_level);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic check_out(input string tag);
        logic eg;
        int   ed;
        int   r;
        r = (n / PS) % RSTEPS;
        if (!run_en) begin
            eg = 1'b0;
            ed = 0;
        end else begin
            if (open_load)     eg = 1'b1;
            else if (ext_mode) eg = ext_pwm_in;
            else               eg = (dim_m == FULL) || (r < dim_m);
            if (!open_load && !ext_mode && dim_m < SSO && r < SSE)
                ed = DMIN + ((DMAX - DMIN) * r) / SSE;
            else
                ed = DMAX;
        end
        checks++;
        if (burst_on !== eg) begin
            errors++;
            $display("FAIL %s burst_on phase=%0d: actual %b expected %b", tag, r, burst_on, eg);
        end
        checks++;
        if (duty_limit !== DW'(ed)) begin
            errors++;
            $display("FAIL %s duty_limit phase=%0d: actual %0d expected %0d", tag, r, duty_limit, ed);
        end
        if (run_en) begin
            checks++;
            if (duty_limit < DMIN || duty_limit > DMAX) begin
                errors++;
                $display("FAIL R10 duty_limit: actual %0d expected %0d..%0d", duty_limit, DMIN, DMAX);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        string tag;
        // Reset state, R7
        repeat (3) tick();
        check_out("R7");
        rst = 1'b0;
        tick();
        check_out("R7");

        // Table walk: each vector restarts run and covers two full phase periods
        for (int v = 0; v < 8; v++) begin
            run_en     = 1'b0;
            dim_level  = VECS[v].dim;
            ext_mode   = VECS[v].ext;
            ext_pwm_in = VECS[v].pwm;
            open_load  = VECS[v].ol;
            tick();
            check_out("R7");
            tag = VECS[v].ol ? "R6 R9" : (VECS[v].ext ? "R5 R9" : "R1 R4 R8 R9");
            run_en = 1'b1;
            for (int c = 0; c < 2 * RSTEPS * PS + 4; c++) begin
                tick();
                check_out(tag);
            end
        end

        // R3: level change mid-period applies only after the wrap
        run_en    = 1'b0;
        ext_mode  = 1'b0;
        open_load = 1'b0;
        dim_level = 6'd10;
        tick();
        run_en = 1'b1;
        for (int c = 0; c < 60; c++) begin
            tick();
            check_out("R3");
        end
        dim_level = 6'd50;
        for (int c = 0; c < 200; c++) begin
            tick();
            check_out("R3");
        end

        // R5: external waveform toggling while the phase runs
        ext_mode = 1'b1;
        for (int c = 0; c < 40; c++) begin
            ext_pwm_in = c[2];
            tick();
            check_out("R5");
        end

        // R6: override asserted mid-period with a closed level
        ext_mode  = 1'b0;
        dim_level = 6'd0;
        open_load = 1'b1;
        for (int c = 0; c < 20; c++) begin
            tick();
            check_out("R6");
        end
        open_load = 1'b0;

        // R7 then R2: leave run mid-period, re-enter and restart at phase 0
        run_en    = 1'b0;
        dim_level = 6'd20;
        tick();
        check_out("R7");
        run_en = 1'b1;
        for (int c = 0; c < 30; c++) begin
            tick();
            check_out("R2");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule